// File: doc/BRIEF.md
# BF16 Exponent Prefix-Code Compression Lane

This lane compresses a stream of 16-bit brain-float words on their way onto a link. Each word is split into a sign bit, an 8-bit exponent and a 7-bit mantissa. Only the exponent is replaced, by a variable-length prefix codeword taken from a loadable table indexed by the exponent value. Sign and mantissa are carried through unchanged, because the mantissa occupies its whole value range and does not compress. The coded fields of consecutive words are concatenated into a packed bitstream and delivered as 32-bit words over a valid/ready output.

Alongside the data path, a small per-lane frequency cache records which exponent values appear during a profiling window of a fixed number of accepted words. External logic reads the gathered tags and counts back through a read port, builds a code from them, and writes the codebook into the table through a write port. Several identical lanes are meant to be placed side by side so that together they match the link rate. Exponents that have no codeword are sent as a reserved escape code followed by their raw 8 bits, and a sticky flag reports that this happened.

Top module: `expcode_lane`

## Requirements
- R1: After reset the lane shows in_ready_o=1, out_valid_o=0, out_last_o=0, esc_flag_o=0, prof_done_o=0, every cache entry invalid (st_vld_o=0), and every table entry empty (length 0).
- R2: The bitstream for each accepted word is the sign bit, then the codeword of its exponent sent most significant bit first (the low cb_len bits of the stored code; bits above that length are ignored), then the 7 mantissa bits from bit 6 down to bit 0. Words are emitted in acceptance order and packed into 32-bit output words, the earliest bit at bit 31.
- R3: A write with cb_we_i=1 stores cb_code_i and cb_len_i into the entry addressed by cb_addr_i (the exponent value). A word accepted in the same cycle as a write uses the previous entry; words accepted later use the new one.
- R4: An entry whose length is 0 or greater than 32 has no codeword; such an exponent is sent as the escape code (parameters ESC_LEN bits of ESC_CODE, most significant first) followed by the 8 raw exponent bits, between the sign and the mantissa.
- R5: esc_flag_o rises in the cycle after a word is accepted through the escape path and then stays high; a codebook write clears it, except when an escape word is accepted in that same cycle, in which case it stays high.
- R6: in_ready_o is high exactly when at most 32 bits are buffered (at least 40 of the 72 buffer bits free) and no flush is pending; a word is accepted when in_valid_i and in_ready_o are both high.
- R7: out_valid_o is high when at least 32 bits are buffered, or when a flush is pending and any bits are buffered; while out_valid_o=1 and out_ready_i=0, out_valid_o and out_data_o hold.
- R8: Accepting a word with in_last_i=1 starts a flush: input is refused until the buffer is empty, the final output word is padded with zeros in its low bits, and out_last_o is high with exactly that word.
- R9: A prof_start_i pulse invalidates all cache entries and opens a window over the next WIN_N accepted words (a word accepted in the start cycle is not counted); prof_done_o rises after the WIN_N-th counted word and stays high until the next start, and no word updates the cache while no window is open.
- R10: A counted word whose exponent matches a valid entry increments that entry's count, saturating at 2^CNT_W-1.
- R11: A counted word that misses while an entry is invalid fills the lowest-indexed invalid entry with its exponent and count 1.
- R12: A counted word that misses when all entries are valid replaces the entry with the lowest count (lowest index on a tie) with its exponent and count 1.
- R13: st_vld_o, st_tag_o and st_cnt_o show, in the same cycle, the valid bit, exponent tag and count of the entry selected by st_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Lane can take a word |
| in_data_i | input | 16 | BF16 word: sign [15], exponent [14:7], mantissa [6:0] |
| in_last_i | input | 1 | Word ends the stream; flush after it |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Downstream takes the output word |
| out_data_o | output | 32 | Packed bitstream word, earliest bit at 31 |
| out_last_o | output | 1 | Final (flushed) word of the stream |
| cb_we_i | input | 1 | Codebook entry write |
| cb_addr_i | input | 8 | Exponent value addressed |
| cb_code_i | input | 32 | Codeword, right-aligned |
| cb_len_i | input | 6 | Codeword length; 0 or above 32 means no codeword |
| esc_flag_o | output | 1 | Sticky: an escape was emitted |
| prof_start_i | input | 1 | Start a profiling window |
| prof_done_o | output | 1 | Profiling window complete |
| st_idx_i | input | $clog2(CACHE_N) | Cache entry selected for reading |
| st_vld_o | output | 1 | Selected entry valid |
| st_tag_o | output | 8 | Selected entry exponent |
| st_cnt_o | output | CNT_W | Selected entry count |

## Verification
The packer can hand out a full 32-bit word and take in a new coded symbol in the same cycle, and the table can be rewritten in the very cycle a word for that exponent is being encoded; both collisions are where the bitstream would most easily be corrupted. The bench provokes them with random output back-pressure while the input stays mostly valid, and with codebook writes scattered into the live stream at the addresses the stream uses, including prof_start_i pulses that land on accepting cycles. A behavioural model holding the pending bits in a queue predicts ready, valid, data, last, the escape flag and the cache contents every clock, and any difference in the collision cycles shows up as a wrong bit position, a wrong codeword choice or a misplaced count.

// File: rtl/expcode_pkg.sv
package expcode_pkg;
  localparam int EXP_W   = 8;
  localparam int MAN_W   = 7;
  localparam int WORD_W  = 1 + EXP_W + MAN_W;
  localparam int CW_MAX  = 32;
  localparam int LEN_W   = 6;
  localparam int OUT_W   = 32;
  localparam int SYM_MAX = 1 + CW_MAX + MAN_W;
  localparam int SLW     = $clog2(SYM_MAX + 1);
  localparam int TBL_N   = 1 << EXP_W;

  typedef struct packed {
    logic [CW_MAX-1:0] code;
    logic [LEN_W-1:0]  len;
  } cb_entry_t;
endpackage

// File: rtl/expcode_table.sv
module expcode_table
  import expcode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [EXP_W-1:0] waddr_i,
  input  cb_entry_t        wdata_i,
  input  logic [EXP_W-1:0] raddr_i,
  output cb_entry_t        rdata_o
);
  cb_entry_t mem_q [TBL_N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TBL_N; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // read sees the old entry during a write cycle
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/expcode_freq_cache.sv
module expcode_freq_cache
  import expcode_pkg::*;
#(
  parameter int N     = 32,
  parameter int CNT_W = 10,
  parameter int WIN_N = 512,
  localparam int IDX_W = $clog2(N),
  localparam int WC_W  = $clog2(WIN_N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             upd_i,
  input  logic [EXP_W-1:0] tag_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_vld_o,
  output logic [EXP_W-1:0] rd_tag_o,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic             done_o
);
  logic             vld_q [N];
  logic [EXP_W-1:0] tag_q [N];
  logic [CNT_W-1:0] cnt_q [N];
  logic             act_q, done_q;
  logic [WC_W-1:0]  wcnt_q;

  logic             hit, free, cnt_en;
  logic [IDX_W-1:0] hit_idx, free_idx, min_idx, vic_idx;
  logic [CNT_W-1:0] min_cnt;

  always_comb begin
    hit = 1'b0; hit_idx = '0;
    free = 1'b0; free_idx = '0;
    min_idx = '0; min_cnt = '1;
    for (int i = 0; i < N; i++) begin
      if (vld_q[i] && tag_q[i] == tag_i && !hit) begin
        hit = 1'b1; hit_idx = IDX_W'(i);
      end
      if (!vld_q[i] && !free) begin
        free = 1'b1; free_idx = IDX_W'(i);
      end
      if (vld_q[i] && cnt_q[i] < min_cnt) begin
        min_cnt = cnt_q[i]; min_idx = IDX_W'(i);
      end
    end
    vic_idx = hit ? hit_idx : (free ? free_idx : min_idx);
  end

  assign cnt_en = upd_i && act_q && !start_i;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic sel;
    assign sel = (vic_idx == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        cnt_q[g] <= '0;
      end else if (start_i) begin
        vld_q[g] <= 1'b0;
      end else if (cnt_en && sel) begin
        if (hit) begin
          if (cnt_q[g] != '1) cnt_q[g] <= cnt_q[g] + CNT_W'(1);
        end else begin
          vld_q[g] <= 1'b1;
          tag_q[g] <= tag_i;
          cnt_q[g] <= CNT_W'(1);
        end
      end
    end

    assert_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!act_q && !start_i) |=> ($stable(cnt_q[g]) && $stable(tag_q[g])));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      wcnt_q <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      done_q <= 1'b0;
      wcnt_q <= '0;
    end else if (cnt_en) begin
      wcnt_q <= wcnt_q + WC_W'(1);
      if (wcnt_q == WC_W'(WIN_N - 1)) begin
        act_q  <= 1'b0;
        done_q <= 1'b1;
      end
    end
  end

  assign rd_vld_o = vld_q[rd_idx_i];
  assign rd_tag_o = tag_q[rd_idx_i];
  assign rd_cnt_o = cnt_q[rd_idx_i];
  assign done_o   = done_q;

  assert_sat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en && hit && cnt_q[hit_idx] == '1) |=> (cnt_q[$past(hit_idx)] == '1));

  assert_alloc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en && !hit && free) |=>
      (vld_q[$past(free_idx)] && cnt_q[$past(free_idx)] == CNT_W'(1)));

  assert_evict_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en && !hit && !free) |=>
      (tag_q[$past(min_idx)] == $past(tag_i) && cnt_q[$past(min_idx)] == CNT_W'(1)));
endmodule

// File: rtl/expcode_packer.sv
module expcode_packer
  import expcode_pkg::*;
#(
  localparam int BUF_W = OUT_W + SYM_MAX,
  localparam int BCW   = $clog2(BUF_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               push_i,
  input  logic [SYM_MAX-1:0] sym_i,
  input  logic [SLW-1:0]     sym_len_i,
  input  logic               last_i,
  input  logic               pop_i,
  output logic               room_o,
  output logic               valid_o,
  output logic [OUT_W-1:0]   data_o,
  output logic               last_o
);
  logic [BUF_W-1:0] buf_q, buf_a, buf_n, sym_left;
  logic [BCW-1:0]   cnt_q, cnt_a, cnt_n;
  logic             flush_q, flush_n, pop;

  assign room_o  = (cnt_q <= BCW'(OUT_W)) && !flush_q;
  assign valid_o = (cnt_q >= BCW'(OUT_W)) || (flush_q && cnt_q != '0);
  assign last_o  = valid_o && flush_q && (cnt_q <= BCW'(OUT_W));
  assign data_o  = buf_q[BUF_W-1 -: OUT_W];
  assign pop     = pop_i && valid_o;

  always_comb begin
    cnt_a = cnt_q;
    buf_a = buf_q;
    if (pop) begin
      cnt_a = (cnt_q >= BCW'(OUT_W)) ? cnt_q - BCW'(OUT_W) : '0;
      buf_a = buf_q << OUT_W;
    end
    // left-align the symbol, then drop it right after the held bits
    sym_left = {sym_i, {OUT_W{1'b0}}} << (SYM_MAX - int'(sym_len_i));
    buf_n = buf_a;
    cnt_n = cnt_a;
    if (push_i) begin
      buf_n = buf_a | (sym_left >> cnt_a);
      cnt_n = cnt_a + BCW'(sym_len_i);
    end
    flush_n = flush_q;
    if (pop && flush_q && cnt_q <= BCW'(OUT_W)) flush_n = 1'b0;
    if (push_i && last_i) flush_n = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      buf_q   <= buf_n;
      cnt_q   <= cnt_n;
      flush_q <= flush_n;
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= BCW'(BUF_W));

  assert_push_room_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> room_o);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pop_i) |=> (valid_o && $stable(data_o)));

  assert_last_once_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && pop_i) |=> !valid_o);
endmodule

// File: rtl/expcode_lane.sv
module expcode_lane
  import expcode_pkg::*;
#(
  parameter int CACHE_N  = 32,
  parameter int CNT_W    = 10,
  parameter int WIN_N    = 512,
  parameter int ESC_LEN  = 4,
  parameter logic [ESC_LEN-1:0] ESC_CODE = '1,
  localparam int IDX_W = $clog2(CACHE_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [WORD_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [OUT_W-1:0]  out_data_o,
  output logic              out_last_o,
  input  logic              cb_we_i,
  input  logic [EXP_W-1:0]  cb_addr_i,
  input  logic [CW_MAX-1:0] cb_code_i,
  input  logic [LEN_W-1:0]  cb_len_i,
  output logic              esc_flag_o,
  input  logic              prof_start_i,
  output logic              prof_done_o,
  input  logic [IDX_W-1:0]  st_idx_i,
  output logic              st_vld_o,
  output logic [EXP_W-1:0]  st_tag_o,
  output logic [CNT_W-1:0]  st_cnt_o
);
  logic               acc, sign, code_ok, esc_q;
  logic [EXP_W-1:0]   exp_v;
  logic [MAN_W-1:0]   man;
  logic [CW_MAX-1:0]  mask;
  logic [SYM_MAX-1:0] sym;
  logic [SLW-1:0]     sym_len;
  cb_entry_t          ent, went;

  assign sign  = in_data_i[WORD_W-1];
  assign exp_v = in_data_i[MAN_W +: EXP_W];
  assign man   = in_data_i[MAN_W-1:0];
  assign acc   = in_valid_i && in_ready_o;
  assign went  = '{code: cb_code_i, len: cb_len_i};

  expcode_table u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cb_we_i),
    .waddr_i (cb_addr_i),
    .wdata_i (went),
    .raddr_i (exp_v),
    .rdata_o (ent)
  );

  always_comb begin
    code_ok = (ent.len != '0) && (int'(ent.len) <= CW_MAX);
    mask    = ~({CW_MAX{1'b1}} << ent.len);
    if (code_ok) begin
      sym = (SYM_MAX'(sign) << (int'(ent.len) + MAN_W))
          | (SYM_MAX'(ent.code & mask) << MAN_W)
          | SYM_MAX'(man);
      sym_len = SLW'(int'(ent.len) + 1 + MAN_W);
    end else begin
      sym = (SYM_MAX'(sign) << (ESC_LEN + EXP_W + MAN_W))
          | (SYM_MAX'(ESC_CODE) << (EXP_W + MAN_W))
          | (SYM_MAX'(exp_v) << MAN_W)
          | SYM_MAX'(man);
      sym_len = SLW'(1 + ESC_LEN + EXP_W + MAN_W);
    end
  end

  expcode_packer u_packer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (acc),
    .sym_i     (sym),
    .sym_len_i (sym_len),
    .last_i    (in_last_i),
    .pop_i     (out_ready_i),
    .room_o    (in_ready_o),
    .valid_o   (out_valid_o),
    .data_o    (out_data_o),
    .last_o    (out_last_o)
  );

  expcode_freq_cache #(
    .N     (CACHE_N),
    .CNT_W (CNT_W),
    .WIN_N (WIN_N)
  ) u_cache (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (prof_start_i),
    .upd_i    (acc),
    .tag_i    (exp_v),
    .rd_idx_i (st_idx_i),
    .rd_vld_o (st_vld_o),
    .rd_tag_o (st_tag_o),
    .rd_cnt_o (st_cnt_o),
    .done_o   (prof_done_o)
  );

  // escape event wins over a clearing write in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) esc_q <= 1'b0;
    else         esc_q <= (esc_q && !cb_we_i) || (acc && !code_ok);
  end
  assign esc_flag_o = esc_q;

  assert_esc_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !code_ok) |=> esc_flag_o);

  assert_esc_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esc_flag_o && !cb_we_i) |=> esc_flag_o);
endmodule

// File: tb/expcode_lane_test.sv
module expcode_lane_test;
  localparam int CACHE_N = 32;
  localparam int CNT_W   = 5;
  localparam int WIN_N   = 160;
  localparam int ESC_LEN = 4;
  localparam logic [ESC_LEN-1:0] ESC_CODE = 4'hF;
  localparam int IDX_W   = $clog2(CACHE_N);
  localparam int CMAX    = (1 << CNT_W) - 1;
  localparam int STREAM_END = 20000;
  localparam int LIMIT      = 60000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic              in_valid, in_ready, in_last, out_valid, out_ready, out_last;
  logic [15:0]       in_data;
  logic [31:0]       out_data;
  logic              cb_we, esc_flag, prof_start, prof_done;
  logic [7:0]        cb_addr;
  logic [31:0]       cb_code;
  logic [5:0]        cb_len;
  logic [IDX_W-1:0]  st_idx;
  logic              st_vld;
  logic [7:0]        st_tag;
  logic [CNT_W-1:0]  st_cnt;

  expcode_lane #(
    .CACHE_N(CACHE_N), .CNT_W(CNT_W), .WIN_N(WIN_N),
    .ESC_LEN(ESC_LEN), .ESC_CODE(ESC_CODE)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data), .in_last_i(in_last),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data), .out_last_o(out_last),
    .cb_we_i(cb_we), .cb_addr_i(cb_addr), .cb_code_i(cb_code), .cb_len_i(cb_len),
    .esc_flag_o(esc_flag), .prof_start_i(prof_start), .prof_done_o(prof_done),
    .st_idx_i(st_idx), .st_vld_o(st_vld), .st_tag_o(st_tag), .st_cnt_o(st_cnt)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, expv);
    end
  endtask

  // reference model state
  bit          q[$];
  bit          m_flush = 0, m_esc = 0, m_act = 0, m_done = 0;
  logic [31:0] m_code [256];
  int          m_len  [256];
  bit          m_vld  [CACHE_N];
  int          m_tag  [CACHE_N];
  int          m_cnt  [CACHE_N];
  int          m_wcnt = 0;
  bit          m_accepted = 0;

  function automatic bit m_ready();
    return (q.size() <= 32) && !m_flush;
  endfunction

  function automatic bit m_valid();
    return (q.size() >= 32) || (m_flush && q.size() > 0);
  endfunction

  function automatic logic [31:0] m_word();
    logic [31:0] w = '0;
    for (int i = 0; i < 32; i++) if (i < q.size()) w[31-i] = q[i];
    return w;
  endfunction

  task automatic model_step();
    bit rdy, vld, acc, ev;
    int n0, e, len;
    rdy = m_ready();
    vld = m_valid();
    n0  = q.size();
    acc = in_valid && rdy;
    ev  = 0;
    m_accepted = acc;
    if (vld && out_ready) begin
      for (int i = 0; i < ((n0 < 32) ? n0 : 32); i++) void'(q.pop_front());
      if (m_flush && n0 <= 32) m_flush = 0;
    end
    e = int'(in_data[14:7]);
    if (acc) begin
      len = m_len[e];
      q.push_back(in_data[15]);
      if (len >= 1 && len <= 32) begin
        for (int i = len - 1; i >= 0; i--) q.push_back(m_code[e][i]);
      end else begin
        ev = 1;
        for (int i = ESC_LEN - 1; i >= 0; i--) q.push_back(ESC_CODE[i]);
        for (int i = 7; i >= 0; i--) q.push_back(in_data[7+i]);
      end
      for (int i = 6; i >= 0; i--) q.push_back(in_data[i]);
      if (in_last) m_flush = 1;
    end
    m_esc = (m_esc && !cb_we) || ev;
    if (cb_we) begin
      m_code[cb_addr] = cb_code;
      m_len[cb_addr]  = int'(cb_len);
    end
    if (prof_start) begin
      for (int i = 0; i < CACHE_N; i++) m_vld[i] = 0;
      m_act = 1; m_wcnt = 0; m_done = 0;
    end else if (acc && m_act) begin
      int h, f, mi;
      h = -1; f = -1; mi = 0;
      for (int i = 0; i < CACHE_N; i++) begin
        if (h < 0 && m_vld[i] && m_tag[i] == e) h = i;
        if (f < 0 && !m_vld[i]) f = i;
      end
      if (h >= 0) begin
        if (m_cnt[h] < CMAX) m_cnt[h]++;
      end else if (f >= 0) begin
        m_vld[f] = 1; m_tag[f] = e; m_cnt[f] = 1;
      end else begin
        for (int i = 1; i < CACHE_N; i++) if (m_cnt[i] < m_cnt[mi]) mi = i;
        m_tag[mi] = e; m_cnt[mi] = 1;
      end
      m_wcnt++;
      if (m_wcnt == WIN_N) begin m_act = 0; m_done = 1; end
    end
  endtask

  task automatic compare();
    bit mv;
    mv = m_valid();
    chk("R6", in_ready, m_ready());
    chk("R7", out_valid, mv);
    if (mv) chk("R2,R3,R4", out_data, m_word());
    chk("R8", out_last, mv && m_flush && q.size() <= 32);
    chk("R5", esc_flag, m_esc);
    chk("R9", prof_done, m_done);
    chk("R11,R12,R13", st_vld, m_vld[st_idx]);
    if (m_vld[st_idx]) begin
      chk("R12,R13", st_tag, m_tag[st_idx]);
      chk("R10,R13", st_cnt, m_cnt[st_idx]);
    end
  endtask

  function automatic logic [15:0] gen_word();
    int r;
    logic [7:0] e;
    r = $urandom % 100;
    if (r < 30)      e = 8'd127;
    else if (r < 60) e = 8'(118 + $urandom % 20);
    else             e = 8'($urandom % 256);
    return {1'($urandom), e, 7'($urandom)};
  endfunction

  initial begin
    int lens [16] = '{1, 2, 3, 4, 5, 6, 7, 8, 12, 16, 20, 24, 32, 0, 40, 10};
    bit final_queued, final_sent, drained;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 256; i++) begin m_code[i] = '0; m_len[i] = 0; end
    for (int i = 0; i < CACHE_N; i++) begin m_vld[i] = 0; m_tag[i] = 0; m_cnt[i] = 0; end
    in_valid = 0; in_data = '0; in_last = 0; out_ready = 0;
    cb_we = 0; cb_addr = '0; cb_code = '0; cb_len = '0;
    prof_start = 0; st_idx = '0;
    final_queued = 0; final_sent = 0; drained = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk("R1", in_ready, 1'b1);
    chk("R1", out_valid, 1'b0);
    chk("R1", out_last, 1'b0);
    chk("R1", esc_flag, 1'b0);
    chk("R1", prof_done, 1'b0);
    chk("R1", st_vld, 1'b0);

    for (int cyc = 0; cyc < LIMIT; cyc++) begin
      @(negedge clk);
      cb_we = 0; prof_start = 0;
      st_idx = IDX_W'(cyc);
      if (cyc < 16) begin
        cb_we = 1; cb_addr = 8'(120 + cyc);
        cb_code = $urandom; cb_len = 6'(lens[cyc]);
        in_valid = 0; out_ready = 0;
      end else if (cyc < STREAM_END) begin
        if (cyc % 2000 == 16) prof_start = 1;
        if ($urandom % 60 == 0) begin
          cb_we = 1; cb_addr = 8'(118 + $urandom % 20);
          cb_code = $urandom; cb_len = 6'($urandom % 41);
        end
        if (!in_valid || m_accepted) begin
          in_valid = ($urandom % 100) < 85;
          in_data  = gen_word();
          in_last  = ($urandom % 40) == 0;
        end
        out_ready = ((cyc / 64) % 4 == 3) ? (($urandom % 4) == 0) : (($urandom % 100) < 75);
      end else begin
        out_ready = 1;
        if (final_queued && m_accepted) final_sent = 1;
        if (!in_valid || m_accepted) begin
          if (!final_queued) begin
            in_valid = 1; in_data = gen_word(); in_last = 1; final_queued = 1;
          end else if (!final_sent && m_accepted && in_last) begin
            final_sent = 1; in_valid = 0; in_last = 0;
          end else if (final_sent) begin
            in_valid = 0; in_last = 0;
          end else begin
            in_valid = 1; in_data = gen_word(); in_last = 1;
          end
        end
        if (final_sent && q.size() == 0 && !m_flush) begin
          drained = 1;
          break;
        end
      end
      #1;
      compare();
      model_step();
    end

    if (!drained) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: stream did not drain actual=0 expected=1");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule